// File: doc/BRIEF.md
# Nonlinear Core Accumulator

This block is the central state register of a hardware stream cipher. On every enabled clock it replaces the whole state with a new value. Each bit is first transformed by a nonlinear rule, and all the transformed bits are then moved to new positions by a fixed bit shuffle. A 10-bit word from the cipher's counter section feeds the low ten bits of the rule. In authenticated-encryption mode, ciphertext bits from the previous round are also XORed into the low part of that word.

The state is split into three zones. The lowest five bits go through a 5-bit bijective substitution. The next five bits are mixed with the upper half of the input word and with a 4-input nonlinear term. All higher bits take a 5-input nonlinear term. Each nonlinear term reads only bits above the bit it updates. Reads past the top of the state return a fixed pad bit. This ordering lets the round be undone from the top bit downward. A round therefore never maps two states to the same result, and no state information is lost.

Top module: `nl_accum`

## Requirements
- R1: A low `rst_n` sampled at a rising edge loads the state with the parameter `INIT` (all zeros in the bench) at that edge.
- R2: While `en` is low, the state keeps its value whatever `din`, `auth_en` and `ct_fb` do.
- R3: Substitution zone. Let d be the effective input word and s the current state. Then t[4:0] = sb(s[4:0]) ^ d[4:0]. Here sb(x) first forms y = (13*x + 5) mod 32, then sets bit k of sb(x) to y[k] ^ (~y[(k+1) mod 5] & y[(k+2) mod 5]).
- R4: Input-mixing zone. For i = 5..9, t[i] = s[i] ^ d[i] ^ ((a & b) ^ (c | e)), where a, b, c, e are s[i+1], s[i+2], s[i+3], s[i+4].
- R5: General zone. For i = 10..W-1, t[i] = s[i] ^ ((a & b) ^ (c | e) ^ (e & f)), where a, b, c, e, f are s[i+1] to s[i+5]. Any index of W or more reads the pad bit `PAD` (1 in the bench).
- R6: Bit t[i] is written to state bit (i*STEP) mod W. STEP must be coprime with W.
- R7: With `auth_en` high, d = `din` XOR `ct_fb` zero-extended, so `ct_fb` lands on the low FB_W bits. With `auth_en` low, d = `din` and `ct_fb` has no effect.
- R8: With `en` high, one full round is done per clock. The new state appears at `state` right after the rising edge.
- R9: For any fixed d, the round maps distinct states to distinct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Round enable |
| din | input | 10 | Counter word |
| auth_en | input | 1 | Authenticated-encryption mode |
| ct_fb | input | FB_W | Previous-round ciphertext feedback |
| state | output | W | Full accumulator state |

## Verification
The bench builds the block with W = 12, STEP = 5 and FB_W = 4. The 12-bit width makes an exhaustive sweep possible: a bench-side instance of the round logic is driven through all 4096 states for several counter words, which checks that no two states collide and that every result matches the model. The same width is small enough to undo the bit shuffle in the bench, so each zone's rule can be compared on its own for both short and long stimulus sequences. The 4-bit feedback width shows that feedback reaches only the low input bits, and only in authenticated mode.

// File: rtl/nl_accum_pkg.sv
// Shared constants and pure functions for the nonlinear core accumulator.
// Assumes the state is at least 12 bits wide, so that all three zones exist.
package nl_accum_pkg;

    localparam int SBOX_W = 5;
    localparam int MIX_W  = 5;
    localparam int IN_W   = SBOX_W + MIX_W;
    localparam int LOOK_W = 5;   // widest nonlinear look-ahead

    // 5-bit bijection: odd-multiplier affine map mod 32, then a chi layer (odd width)
    function automatic logic [SBOX_W-1:0] sbox5(input logic [SBOX_W-1:0] x);
        logic [SBOX_W-1:0] y;
        logic [SBOX_W-1:0] z;
        y = x * 5'd13 + 5'd5;
        for (int k = 0; k < SBOX_W; k++) begin
            z[k] = y[k] ^ (~y[(k + 1) % SBOX_W] & y[(k + 2) % SBOX_W]);
        end
        return z;
    endfunction

    // 4-input nonlinear term for the input-mixing zone
    function automatic logic nl4(input logic a, input logic b, input logic c, input logic e);
        return (a & b) ^ (c | e);
    endfunction

    // 5-input nonlinear term for the general zone
    function automatic logic nl5(input logic a, input logic b, input logic c,
                                 input logic e, input logic f);
        return (a & b) ^ (c | e) ^ (e & f);
    endfunction

    // Destination bit of pre-shuffle bit i
    function automatic int perm_dst(input int i, input int w, input int step);
        return (i * step) % w;
    endfunction

endpackage

// File: rtl/nl_accum_subst.sv
// Substitution layer: applies the three zone rules to every state bit at once.
// Each nonlinear term reads only higher-index bits; reads past the top return PAD.
// Assumes W >= 12.
module nl_accum_subst
    import nl_accum_pkg::*;
#(
    parameter int   W   = 83,
    parameter logic PAD = 1'b1
) (
    input  logic [W-1:0]    state_i,
    input  logic [IN_W-1:0] din_i,
    output logic [W-1:0]    sub_o
);

    localparam int EXT_W = W + LOOK_W;

    logic [EXT_W-1:0] ext;

    // Extend the state with pad bits so that top look-ahead reads are defined
    assign ext = {{LOOK_W{PAD}}, state_i};

    // Substitution zone: bijective 5-bit box plus the low input bits
    assign sub_o[SBOX_W-1:0] = sbox5(state_i[SBOX_W-1:0]) ^ din_i[SBOX_W-1:0];

    // Input-mixing zone: upper input bits plus a 4-input term
    for (genvar i = SBOX_W; i < IN_W; i++) begin : g_mix
        assign sub_o[i] = state_i[i] ^ din_i[i]
                        ^ nl4(ext[i+1], ext[i+2], ext[i+3], ext[i+4]);
    end

    // General zone: a 5-input term from the next higher bits
    for (genvar i = IN_W; i < W; i++) begin : g_gen
        assign sub_o[i] = state_i[i]
                        ^ nl5(ext[i+1], ext[i+2], ext[i+3], ext[i+4], ext[i+5]);
    end

endmodule

// File: rtl/nl_accum_perm.sv
// Fixed bit shuffle: bit i moves to (i*STEP) mod W.
// Assumes STEP is coprime with W, so each output bit has exactly one driver.
module nl_accum_perm
    import nl_accum_pkg::*;
#(
    parameter int W    = 83,
    parameter int STEP = 17
) (
    input  logic [W-1:0] sub_i,
    output logic [W-1:0] perm_o
);

    // One wire per bit, placed by the stride rule
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign perm_o[perm_dst(i, W, STEP)] = sub_i[i];
    end

endmodule

// File: rtl/nl_accum_round.sv
// One full combinational round: the substitution layer followed by the bit shuffle.
// Purely combinational; the caller registers the result.
module nl_accum_round
    import nl_accum_pkg::*;
#(
    parameter int   W    = 83,
    parameter int   STEP = 17,
    parameter logic PAD  = 1'b1
) (
    input  logic [W-1:0]    state_i,
    input  logic [IN_W-1:0] din_i,
    output logic [W-1:0]    sub_o,
    output logic [W-1:0]    next_o
);

    nl_accum_subst #(.W(W), .PAD(PAD)) u_subst (
        .state_i (state_i),
        .din_i   (din_i),
        .sub_o   (sub_o)
    );

    nl_accum_perm #(.W(W), .STEP(STEP)) u_perm (
        .sub_i  (sub_o),
        .perm_o (next_o)
    );

endmodule

// File: rtl/nl_accum.sv
// Nonlinear core accumulator: a state register advanced by one bijective round
// per enabled clock. Ciphertext feedback is folded into the low input bits in
// authenticated mode. Assumes FB_W <= 10, W >= 12 and gcd(W, STEP) == 1.
module nl_accum
    import nl_accum_pkg::*;
#(
    parameter int           W    = 83,
    parameter int           STEP = 17,
    parameter int           FB_W = 10,
    parameter logic         PAD  = 1'b1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [IN_W-1:0] din,
    input  logic            auth_en,
    input  logic [FB_W-1:0] ct_fb,
    output logic [W-1:0]    state
);

    logic [IN_W-1:0] fb_ext;
    logic [IN_W-1:0] din_eff;
    logic [W-1:0]    state_q;
    logic [W-1:0]    sub_w;
    logic [W-1:0]    nxt_w;

    // Zero-extend the feedback bus to the input word width
    assign fb_ext = IN_W'(ct_fb);

    // Effective input word: feedback folded in only in authenticated mode
    always_comb begin
        din_eff = din;
        if (auth_en) begin
            din_eff = din ^ fb_ext;
        end
    end

    nl_accum_round #(.W(W), .STEP(STEP), .PAD(PAD)) u_round (
        .state_i (state_q),
        .din_i   (din_eff),
        .sub_o   (sub_w),
        .next_o  (nxt_w)
    );

    // State register: synchronous reset, otherwise advance when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT;
        end else if (en) begin
            state_q <= nxt_w;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/nl_accum_chk.sv
// Property checker for nl_accum, attached to every instance through bind.
module nl_accum_chk
    import nl_accum_pkg::*;
#(
    parameter int           W    = 83,
    parameter int           STEP = 17,
    parameter int           FB_W = 10,
    parameter logic [W-1:0] INIT = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            auth_en,
    input logic [IN_W-1:0] din,
    input logic [FB_W-1:0] ct_fb,
    input logic [IN_W-1:0] din_eff,
    input logic [W-1:0]    state_q,
    input logic [W-1:0]    sub_w
);

    p_reset_load_r1: assert property (@(posedge clk)
        !rst_n |=> state_q == INIT);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q));

    // R3: the substitution zone reads nothing outside its own bits and input bits
    p_sbox_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(state_q[SBOX_W-1:0]) && $stable(din_eff[SBOX_W-1:0]))
        |-> $stable(sub_w[SBOX_W-1:0]));

    // R5: the top bit depends only on itself and the pad
    p_top_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_q[W-1]) |-> $stable(sub_w[W-1]));

    // R7: with authenticated mode off, feedback changes leave the input untouched
    p_fb_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!auth_en && $stable(auth_en) && $stable(din) && !$stable(ct_fb))
        |-> $stable(din_eff));

    // R6: each substituted bit lands at its shuffled position after the edge
    for (genvar i = 0; i < W; i++) begin : g_perm
        p_perm_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> state_q[perm_dst(i, W, STEP)] == $past(sub_w[i]));
    end

endmodule

bind nl_accum nl_accum_chk #(
    .W(W), .STEP(STEP), .FB_W(FB_W), .INIT(INIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .auth_en (auth_en),
    .din     (din),
    .ct_fb   (ct_fb),
    .din_eff (din_eff),
    .state_q (state_q),
    .sub_w   (sub_w)
);

// File: tb/nl_accum_tb.sv
// Scoreboard bench: the driver pushes model results, the monitor pops and compares.
module nl_accum_tb;

    localparam int   W    = 12;
    localparam int   STEP = 5;
    localparam int   FB_W = 4;
    localparam logic PAD  = 1'b1;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic            clk     = 1'b0;
    logic            rst_n   = 1'b0;
    logic            en      = 1'b0;
    logic            auth_en = 1'b0;
    logic [9:0]      din     = '0;
    logic [FB_W-1:0] ct_fb   = '0;
    logic [W-1:0]    state;

    logic [W-1:0]    sw_s = '0;
    logic [9:0]      sw_d = '0;
    logic [W-1:0]    sw_sub;
    logic [W-1:0]    sw_n;

    int     n_checks = 0;
    int     n_errors = 0;
    item_t  q[$];
    item_t  it;
    logic [W-1:0] mstate = '0;

    always #5 clk = ~clk;

    nl_accum #(.W(W), .STEP(STEP), .FB_W(FB_W), .PAD(PAD), .INIT('0)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .din(din),
        .auth_en(auth_en), .ct_fb(ct_fb), .state(state)
    );

    nl_accum_round #(.W(W), .STEP(STEP), .PAD(PAD)) u_sweep (
        .state_i(sw_s), .din_i(sw_d), .sub_o(sw_sub), .next_o(sw_n)
    );

    // ---- reference model written from the requirements ----
    function automatic logic [4:0] m_sbox(input logic [4:0] x);
        logic [4:0] y, z;
        y = x * 5'd13 + 5'd5;
        for (int k = 0; k < 5; k++) z[k] = y[k] ^ (~y[(k+1)%5] & y[(k+2)%5]);
        return z;
    endfunction

    function automatic logic m_bit(input logic [W-1:0] s, input int k);
        return (k < W) ? s[k] : PAD;
    endfunction

    function automatic logic [W-1:0] m_sub(input logic [W-1:0] s, input logic [9:0] d);
        logic [W-1:0] t;
        t[4:0] = m_sbox(s[4:0]) ^ d[4:0];
        for (int i = 5; i < 10; i++)
            t[i] = s[i] ^ d[i] ^ ((m_bit(s,i+1) & m_bit(s,i+2)) ^ (m_bit(s,i+3) | m_bit(s,i+4)));
        for (int i = 10; i < W; i++)
            t[i] = s[i] ^ ((m_bit(s,i+1) & m_bit(s,i+2)) ^ (m_bit(s,i+3) | m_bit(s,i+4))
                          ^ (m_bit(s,i+4) & m_bit(s,i+5)));
        return t;
    endfunction

    function automatic logic [W-1:0] m_perm(input logic [W-1:0] t);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[(i*STEP)%W] = t[i];
        return r;
    endfunction

    function automatic logic [W-1:0] m_unperm(input logic [W-1:0] r);
        logic [W-1:0] t;
        for (int i = 0; i < W; i++) t[i] = r[(i*STEP)%W];
        return t;
    endfunction

    function automatic logic [9:0] m_din(input logic [9:0] d, input logic a,
                                         input logic [FB_W-1:0] f);
        return a ? (d ^ 10'(f)) : d;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected state
    task automatic step(input logic r, input logic e, input logic a,
                        input logic [9:0] d, input logic [FB_W-1:0] f, input string tag);
        rst_n = r; en = e; auth_en = a; din = d; ct_fb = f;
        if (!r)      mstate = '0;
        else if (e)  mstate = m_perm(m_sub(mstate, m_din(d, a, f)));
        q.push_back('{mstate, tag});
        @(negedge clk);
    endtask

    // Monitor: after each edge, compare per zone (shuffle undone) and in full
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            check("R3", W'(m_unperm(state) & 12'h01F), W'(m_unperm(it.exp) & 12'h01F));
            check("R4", W'(m_unperm(state) & 12'h3E0), W'(m_unperm(it.exp) & 12'h3E0));
            check("R5", W'(m_unperm(state) & 12'hC00), W'(m_unperm(it.exp) & 12'hC00));
            check(it.tag, state, it.exp);
        end
    end

    initial begin
        #100000;
        n_errors++;
        n_checks++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [9:0] lf;
        bit         seen [4096];
        int         dup, mis;
        logic [9:0] dset [3];
        // R1: reset state
        step(1'b0, 1'b0, 1'b0, 10'h000, 4'h0, "R1");
        step(1'b0, 1'b1, 1'b0, 10'h3FF, 4'hF, "R1");
        step(1'b0, 1'b0, 1'b0, 10'h000, 4'h0, "R1");
        // R8: one round per enabled clock, several input patterns
        step(1'b1, 1'b1, 1'b0, 10'h000, 4'h0, "R8");
        step(1'b1, 1'b1, 1'b0, 10'h3FF, 4'h0, "R8");
        step(1'b1, 1'b1, 1'b0, 10'h155, 4'h0, "R8");
        step(1'b1, 1'b1, 1'b0, 10'h2AA, 4'h0, "R8");
        step(1'b1, 1'b1, 1'b0, 10'h001, 4'h0, "R8");
        step(1'b1, 1'b1, 1'b0, 10'h200, 4'h0, "R8");
        // R7: feedback ignored when mode is off
        step(1'b1, 1'b1, 1'b0, 10'h0F0, 4'hF, "R7");
        step(1'b1, 1'b1, 1'b0, 10'h00F, 4'h5, "R7");
        // R7: feedback folded in when mode is on
        step(1'b1, 1'b1, 1'b1, 10'h0F0, 4'hF, "R7");
        step(1'b1, 1'b1, 1'b1, 10'h000, 4'h9, "R7");
        step(1'b1, 1'b1, 1'b1, 10'h3C3, 4'h6, "R7");
        // R2: hold while disabled, inputs moving
        step(1'b1, 1'b0, 1'b1, 10'h3FF, 4'hF, "R2");
        step(1'b1, 1'b0, 1'b0, 10'h123, 4'hA, "R2");
        step(1'b1, 1'b0, 1'b1, 10'h000, 4'h3, "R2");
        // R1: reset in the middle of a run
        step(1'b0, 1'b1, 1'b1, 10'h2B1, 4'h7, "R1");
        // R6: long mixed sequence
        lf = 10'h2D3;
        for (int n = 0; n < 60; n++) begin
            lf = {lf[8:0], lf[9] ^ lf[6]};
            step(1'b1, (n % 7) != 3, lf[0], lf, lf[4:1], "R6");
        end
        @(negedge clk);
        @(negedge clk);
        // R9 and R6: exhaustive sweep of the stand-alone round
        dset[0] = 10'h000; dset[1] = 10'h3A5; dset[2] = 10'h3FF;
        for (int j = 0; j < 3; j++) begin
            dup = 0; mis = 0;
            for (int s = 0; s < 4096; s++) seen[s] = 1'b0;
            sw_d = dset[j];
            for (int s = 0; s < 4096; s++) begin
                sw_s = W'(s);
                #1;
                if (sw_n !== m_perm(m_sub(W'(s), dset[j]))) mis++;
                if (seen[sw_n]) dup++;
                seen[sw_n] = 1'b1;
            end
            n_checks++;
            if (dup != 0) begin
                n_errors++;
                $display("FAIL R9: actual=%0d collisions expected=0 (din=%h)", dup, dset[j]);
            end
            n_checks++;
            if (mis != 0) begin
                n_errors++;
                $display("FAIL R6: actual=%0d model mismatches expected=0 (din=%h)", mis, dset[j]);
            end
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule